// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Strobe Controller

This block sits between a synchronous host and a 2048 x 8 asynchronous static RAM. The RAM has no output-enable pin. It has an active-low select, an active-high standby select, an active-low write strobe and one shared bidirectional data bus. The controller takes one read or one write per handshake. It holds the address for the whole access and produces the select and write strobes in whole clock cycles. It drives the shared bus only while the RAM's own output is forced to high-Z.

Every timing figure is a parameter counted in clock cycles. The defaults suit a 20 ns clock and the fastest speed grade: a read lasts 6 cycles and the write pulse lasts 5 cycles. A sleep input parks the RAM in its low-power state whenever the controller is idle. On wake-up the controller waits for a recovery interval before it accepts new work. The data bus is split into an input, an output and a driver enable, so that the three-state buffer can be placed at the pad.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, mem_ce1_no=1, mem_ce2_o=0, mem_we_no=1, mem_dq_oe_o=0 and rvalid_o=0. ready_o=1 while sleep_i=0.
- R2: A request is accepted on a rising edge where req_i=1 and ready_o=1. we_i=1 marks a write and we_i=0 marks a read. ready_o is 0 from the cycle after acceptance until the access is complete. It returns to 1 in the first idle cycle.
- R3: A read holds mem_ce1_no=0, mem_we_no=1 and mem_dq_oe_o=0 for RD_CYC cycles, starting the cycle after acceptance. mem_addr_o equals the accepted address throughout.
- R4: Read data is sampled from mem_dq_i on the edge that ends the last read cycle. rdata_o shows it and rvalid_o is 1 for exactly the next cycle. rdata_o then holds its value.
- R5: A write first spends WS_CYC cycles with mem_ce1_no=1, mem_we_no=1 and mem_dq_oe_o=0 while the new address is driven. It then spends exactly WP_CYC cycles with mem_ce1_no=0, mem_we_no=0, mem_dq_oe_o=1 and mem_dq_o equal to the write data. mem_ce1_no and mem_we_no fall on the same edge, and mem_we_no is never low while mem_ce1_no is high.
- R6: After the write pulse, mem_ce1_no and mem_we_no rise together. The write data stays driven (mem_dq_oe_o=1) for WH_CYC more cycles, and is then released.
- R7: mem_dq_oe_o is never 1 in a cycle where the RAM is in read mode (mem_ce1_no=0, mem_ce2_o=0, mem_we_no=1).
- R8: mem_addr_o does not change between two consecutive cycles that both have mem_ce1_no=0.
- R9: If sleep_i=1 while idle, ready_o is 0 at once and mem_ce2_o is 1 from the next cycle, with mem_ce1_no=1, mem_we_no=1 and mem_dq_oe_o=0. No request is accepted while asleep.
- R10: After sleep_i falls, mem_ce2_o is 0 from the next cycle. ready_o stays 0 for WAKE_CYC cycles and then returns to 1.
- R11: A read returns the byte last written to the same address, including addresses 0x000 and 0x7FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Access address |
| wdata_i | input | DATA_W | Write data |
| sleep_i | input | 1 | Standby request, acted on when idle |
| ready_o | output | 1 | Controller can accept a request |
| rdata_o | output | DATA_W | Last read data |
| rvalid_o | output | 1 | One-cycle pulse: rdata_o is new |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_ce1_no | output | 1 | RAM select, active low |
| mem_ce2_o | output | 1 | RAM standby select, high = standby |
| mem_we_no | output | 1 | RAM write strobe, active low |
| mem_dq_i | input | DATA_W | Data from the RAM bus |
| mem_dq_o | output | DATA_W | Data to the RAM bus |
| mem_dq_oe_o | output | 1 | Bus driver enable |

## Verification
Cycle j counts from the acceptance edge, with j=0 the cycle that follows it. A read shows its strobes in cycles 0 to RD_CYC-1. rvalid_o and the data arrive in cycle RD_CYC and are gone in cycle RD_CYC+1. A write has its setup cycle at j=0, the pulse in cycles 1 to WP_CYC, and the hold cycle right after, with the bus released one cycle later. Standby shows on mem_ce2_o one cycle after sleep_i is applied to an idle controller, and ready_o returns WAKE_CYC cycles after the wake edge. The bench drives inputs and samples outputs on falling edges, and compares each cycle j against these offsets.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR_SET,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_SLEEP,
    ST_WAKE
  } ctrl_state_e;

  typedef struct packed {
    logic ce1_n;
    logic ce2;
    logic we_n;
    logic drive;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{ce1_n: 1'b1, ce2: 1'b0, we_n: 1'b1, drive: 1'b0};

  function automatic strobe_t strobe_of(ctrl_state_e s);
    strobe_t r;
    r = STROBE_IDLE;
    case (s)
      ST_RD:       r.ce1_n = 1'b0;
      ST_WR_PULSE: begin
        r.ce1_n = 1'b0;
        r.we_n  = 1'b0;
        r.drive = 1'b1;
      end
      ST_WR_HOLD:  r.drive = 1'b1;
      ST_SLEEP:    r.ce2   = 1'b1;
      default:     ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm import sram_ctrl_pkg::*; #(
  parameter int RD_CYC   = 6,
  parameter int WS_CYC   = 1,
  parameter int WP_CYC   = 5,
  parameter int WH_CYC   = 1,
  parameter int WAKE_CYC = 6,
  parameter int CNT_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             sleep_i,
  input  logic             tmr_done_i,
  output ctrl_state_e      state_d_o,
  output logic             ready_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o
);

  localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WS_LD   = CNT_W'(WS_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] WH_LD   = CNT_W'(WH_CYC - 1);
  localparam logic [CNT_W-1:0] WAKE_LD = CNT_W'(WAKE_CYC - 1);

  ctrl_state_e state_q, state_d;

  assign ready_o   = (state_q == ST_IDLE) && !sleep_i;
  assign accept_o  = ready_o && req_i;
  assign capture_o = (state_q == ST_RD) && tmr_done_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (sleep_i)       state_d = ST_SLEEP;
        else if (req_i)    state_d = we_i ? ST_WR_SET : ST_RD;
      end
      ST_RD:       if (tmr_done_i) state_d = ST_IDLE;
      ST_WR_SET:   if (tmr_done_i) state_d = ST_WR_PULSE;
      ST_WR_PULSE: if (tmr_done_i) state_d = ST_WR_HOLD;
      ST_WR_HOLD:  if (tmr_done_i) state_d = ST_IDLE;
      ST_SLEEP:    if (!sleep_i)   state_d = ST_WAKE;
      ST_WAKE:     if (tmr_done_i) state_d = ST_IDLE;
      default:                     state_d = ST_IDLE;
    endcase
  end

  // every timed state loads its length on entry
  always_comb begin
    tmr_load_o = (state_d != state_q);
    case (state_d)
      ST_RD:       tmr_val_o = RD_LD;
      ST_WR_SET:   tmr_val_o = WS_LD;
      ST_WR_PULSE: tmr_val_o = WP_LD;
      ST_WR_HOLD:  tmr_val_o = WH_LD;
      ST_WAKE:     tmr_val_o = WAKE_LD;
      default:     tmr_val_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_d_o = state_d;

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvalid_q;

  // address only moves on the acceptance edge, when the select is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture_i;
      if (capture_i) rdata_q <= mem_dq_i;
    end
  end

  assign mem_addr_o = addr_q;
  assign mem_dq_o   = wdata_q;
  assign rdata_o    = rdata_q;
  assign rvalid_o   = rvalid_q;

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl import sram_ctrl_pkg::*; #(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int RD_CYC   = 6,
  parameter int WS_CYC   = 1,
  parameter int WP_CYC   = 5,
  parameter int WH_CYC   = 1,
  parameter int WAKE_CYC = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sleep_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce1_no,
  output logic              mem_ce2_o,
  output logic              mem_we_no,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o
);

  localparam int MAX_A   = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
  localparam int MAX_B   = (WS_CYC > WH_CYC) ? WS_CYC : WH_CYC;
  localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC = (MAX_C > WAKE_CYC) ? MAX_C : WAKE_CYC;
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  ctrl_state_e      state_d;
  logic             accept, capture, tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  strobe_t          strobe_q;

  sram_ctrl_fsm #(
    .RD_CYC(RD_CYC), .WS_CYC(WS_CYC), .WP_CYC(WP_CYC),
    .WH_CYC(WH_CYC), .WAKE_CYC(WAKE_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .sleep_i    (sleep_i),
    .tmr_done_i (tmr_done),
    .state_d_o  (state_d),
    .ready_o    (ready_o),
    .accept_o   (accept),
    .capture_o  (capture),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val)
  );

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .capture_i  (capture),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .mem_dq_i   (mem_dq_i),
    .mem_addr_o (mem_addr_o),
    .mem_dq_o   (mem_dq_o),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );

  // strobes come straight from flops, decoded from the next state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= STROBE_IDLE;
    else         strobe_q <= strobe_of(state_d);
  end

  assign mem_ce1_no  = strobe_q.ce1_n;
  assign mem_ce2_o   = strobe_q.ce2;
  assign mem_we_no   = strobe_q.we_n;
  assign mem_dq_oe_o = strobe_q.drive;

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
  parameter int ADDR_W = 11,
  parameter int WP_CYC = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              rvalid_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ce1_no,
  input logic              mem_ce2_o,
  input logic              mem_we_no,
  input logic              mem_dq_oe_o
);

  localparam logic [15:0] WP_L = 16'(WP_CYC);

  logic [15:0] we_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         we_run_q <= '0;
    else if (!mem_we_no) we_run_q <= we_run_q + 16'd1;
    else                 we_run_q <= '0;
  end

  a_r7_no_bus_fight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> !(!mem_ce1_no && !mem_ce2_o && mem_we_no));

  a_r8_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce1_no && $past(!mem_ce1_no)) |-> $stable(mem_addr_o));

  a_r5_we_inside_ce1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_ce1_no && mem_dq_oe_o));

  a_r5_pulse_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (we_run_q == WP_L));

  a_r6_hold_after_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (mem_dq_oe_o && mem_ce1_no));

  a_r4_rvalid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  a_r2_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce1_no || mem_dq_oe_o) |-> !ready_o);

  a_r9_standby_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ce2_o |-> (mem_ce1_no && mem_we_no && !mem_dq_oe_o && !ready_o));

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(.ADDR_W(ADDR_W), .WP_CYC(WP_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ready_o     (ready_o),
  .rvalid_o    (rvalid_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ce1_no  (mem_ce1_no),
  .mem_ce2_o   (mem_ce2_o),
  .mem_we_no   (mem_we_no),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/sram_strobe_ctrl_bench.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_bench;

  localparam int RD_CYC   = 6;
  localparam int WS_CYC   = 1;
  localparam int WP_CYC   = 5;
  localparam int WH_CYC   = 1;
  localparam int WAKE_CYC = 6;
  localparam int NVEC     = 11;

  // {write, addr[10:0], data[7:0]}
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b1, 11'h000, 8'hA5}, {1'b1, 11'h7FF, 8'h3C}, {1'b1, 11'h155, 8'h0F},
    {1'b0, 11'h000, 8'h00}, {1'b0, 11'h7FF, 8'h00}, {1'b0, 11'h155, 8'h00},
    {1'b1, 11'h000, 8'h5A}, {1'b0, 11'h000, 8'h00}, {1'b0, 11'h2AA, 8'h00},
    {1'b1, 11'h7FF, 8'hC3}, {1'b0, 11'h7FF, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, sleep = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready_o, rvalid_o, mem_ce1_no, mem_ce2_o, mem_we_no, mem_dq_oe_o;
  logic [7:0]  rdata_o, mem_dq_i, mem_dq_o;
  logic [10:0] mem_addr_o;

  logic [7:0] ram     [2048];
  logic [7:0] exp_mem [2048];

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sram_strobe_ctrl u_sram_strobe_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .sleep_i(sleep), .ready_o(ready_o), .rdata_o(rdata_o),
    .rvalid_o(rvalid_o), .mem_addr_o(mem_addr_o), .mem_ce1_no(mem_ce1_no),
    .mem_ce2_o(mem_ce2_o), .mem_we_no(mem_we_no), .mem_dq_i(mem_dq_i),
    .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o)
  );

  // RAM model: drives the bus in read mode, stores on a selected write strobe
  always_comb
    mem_dq_i = (!mem_ce1_no && !mem_ce2_o && mem_we_no) ? ram[mem_addr_o] : 8'hzz;

  always @(posedge clk)
    if (!mem_ce1_no && !mem_ce2_o && !mem_we_no && mem_dq_oe_o) ram[mem_addr_o] <= mem_dq_o;

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic do_access(input logic w, input logic [10:0] a, input logic [7:0] d);
    bit ok;
    int guard = 0;
    while (!ready_o && guard < 100) begin @(negedge clk); guard++; end
    req = 1'b1; we = w; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);                     // cycle j=0
    req = 1'b0;
    if (!w) begin
      ok = 1'b1;
      for (int j = 0; j < RD_CYC; j++) begin
        if (j > 0) @(negedge clk);
        if (mem_ce1_no !== 1'b0 || mem_we_no !== 1'b1 || mem_dq_oe_o !== 1'b0 ||
            mem_addr_o !== a || ready_o !== 1'b0 || rvalid_o !== 1'b0) ok = 1'b0;
      end
      check(ok, "R3 read strobes/address", {21'd0, mem_addr_o}, {21'd0, a});
      @(negedge clk);                   // cycle j=RD_CYC
      check(rvalid_o === 1'b1 && rdata_o === exp_mem[a], "R4/R11 read data",
            {23'd0, rvalid_o, rdata_o}, {23'd1, exp_mem[a]});
      check(ready_o === 1'b1 && mem_ce1_no === 1'b1, "R2 ready after read",
            {30'd0, ready_o, mem_ce1_no}, 32'd3);
      @(negedge clk);
      check(rvalid_o === 1'b0 && rdata_o === exp_mem[a], "R4 single pulse, data held",
            {23'd0, rvalid_o, rdata_o}, {24'd0, exp_mem[a]});
    end else begin
      ok = 1'b1;
      for (int j = 0; j < WS_CYC; j++) begin
        if (j > 0) @(negedge clk);
        if (mem_ce1_no !== 1'b1 || mem_we_no !== 1'b1 || mem_dq_oe_o !== 1'b0 ||
            mem_addr_o !== a || ready_o !== 1'b0) ok = 1'b0;
      end
      check(ok, "R5 write setup", {21'd0, mem_addr_o}, {21'd0, a});
      ok = 1'b1;
      for (int j = 0; j < WP_CYC; j++) begin
        @(negedge clk);
        if (mem_ce1_no !== 1'b0 || mem_we_no !== 1'b0 || mem_dq_oe_o !== 1'b1 ||
            mem_dq_o !== d || mem_addr_o !== a) ok = 1'b0;
      end
      check(ok, "R5 write pulse", {24'd0, mem_dq_o}, {24'd0, d});
      ok = 1'b1;
      for (int j = 0; j < WH_CYC; j++) begin
        @(negedge clk);
        if (mem_ce1_no !== 1'b1 || mem_we_no !== 1'b1 || mem_dq_oe_o !== 1'b1 ||
            mem_dq_o !== d || ready_o !== 1'b0) ok = 1'b0;
      end
      check(ok, "R6 data hold", {31'd0, mem_dq_oe_o}, 32'd1);
      @(negedge clk);
      check(mem_dq_oe_o === 1'b0 && ready_o === 1'b1, "R6/R2 bus released",
            {30'd0, mem_dq_oe_o, ready_o}, 32'd1);
      exp_mem[a] = d;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=expired expected=done");
    summary();
    $finish;
  end

  initial begin
    bit ok;
    for (int i = 0; i < 2048; i++) begin
      ram[i]     = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    check(mem_ce1_no === 1'b1 && mem_ce2_o === 1'b0 && mem_we_no === 1'b1 &&
          mem_dq_oe_o === 1'b0 && rvalid_o === 1'b0, "R1 reset strobes",
          {27'd0, mem_ce1_no, mem_ce2_o, mem_we_no, mem_dq_oe_o, rvalid_o}, 32'h14);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready_o === 1'b1 && mem_ce1_no === 1'b1, "R1 ready after reset",
          {31'd0, ready_o}, 32'd1);

    for (int i = 0; i < NVEC; i++)
      do_access(VEC[i][19], VEC[i][18:8], VEC[i][7:0]);

    // R9: sleep while idle, request held off
    sleep = 1'b1; req = 1'b1; we = 1'b0; addr = 11'h005;
    #1;
    check(ready_o === 1'b0, "R9 ready drops with sleep", {31'd0, ready_o}, 32'd0);
    @(negedge clk);
    check(mem_ce2_o === 1'b1 && mem_ce1_no === 1'b1 && mem_dq_oe_o === 1'b0,
          "R9 standby entered", {29'd0, mem_ce2_o, mem_ce1_no, mem_dq_oe_o}, 32'd6);
    ok = 1'b1;
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      if (mem_ce1_no !== 1'b1 || mem_ce2_o !== 1'b1 || ready_o !== 1'b0 || rvalid_o !== 1'b0) ok = 1'b0;
    end
    check(ok, "R9 request held off in standby", {31'd0, mem_ce1_no}, 32'd1);

    // R10: wake and recovery
    sleep = 1'b0; req = 1'b0;
    @(negedge clk);
    check(mem_ce2_o === 1'b0 && ready_o === 1'b0, "R10 standby released",
          {30'd0, mem_ce2_o, ready_o}, 32'd0);
    ok = 1'b1;
    for (int j = 1; j < WAKE_CYC; j++) begin
      @(negedge clk);
      if (ready_o !== 1'b0 || mem_ce1_no !== 1'b1) ok = 1'b0;
    end
    check(ok, "R10 recovery wait", {31'd0, ready_o}, 32'd0);
    @(negedge clk);
    check(ready_o === 1'b1, "R10 ready after recovery", {31'd0, ready_o}, 32'd1);

    do_access(1'b1, 11'h005, 8'h77);
    do_access(1'b0, 11'h005, 8'h00);

    summary();
    $finish;
  end

endmodule